// File: doc/BRIEF.md
# Line-Output Mute Sequencer

This controller owns the mute line of an audio line output and the power controls of the DAC feeding it. Its job is to keep any start-up transient away from the output. Out of reset it leaves the mute pin undriven, so an external pull keeps the line muted. It then drives the pin at its mute level, powers up the DAC, and enables the analog drivers. Mute stays asserted until a programmable number of timebase ticks has elapsed with the drivers on. Only then does it release the output.

There are two ways to release. In step mode the pin goes straight to the unmute level. In fade mode the controller stops driving the pin and raises `fade_start`. An external fade driver then ramps the line over a period of seconds. The controller waits for `fade_done` before it treats the output as running. A mute request while the output is running or releasing mutes the output on the next clock edge, with no ramp. When the request drops, the settle wait starts again from zero before a new release.

The fade start/done pair is a plain level handshake, not a data stream, so there is no back-pressure. `fade_start` stays high until `fade_done` is seen high, or until a mute request aborts the release.

Top module: `mute_seq_ctrl`

## Requirements
- R1: While `rst_n` is low: `mute_oe`=0, `mute_out`=MUTE_LVL, `dac_pwrdn`=1, `dac_drv_en`=0, `fade_start`=0.
- R2: On the first clock edge after reset is released, `mute_oe` goes to 1 with `mute_out`=MUTE_LVL. `dac_pwrdn` stays 1.
- R3: On the second edge, `dac_pwrdn` drops to 0 while mute is still driven. `dac_drv_en` rises on the third edge, never earlier.
- R4: `dac_drv_en` is never 1 while `dac_pwrdn` is 1.
- R5: Mute stays driven until SETTLE_TICKS clock cycles with `tick_en`=1 have been counted after `dac_drv_en` rose. Ticks before that point do not count. In step mode (`fade_mode`=0), the edge after the last counted tick sets `mute_out` to the unmute level (not MUTE_LVL) with `mute_oe`=1.
- R6: In fade mode (`fade_mode`=1), that edge instead sets `fade_start`=1 and `mute_oe`=0, and both hold until `fade_done`=1 is sampled. The next edge then sets `fade_start`=0, `mute_oe`=1 and the unmute level.
- R7: `mute_req`=1 while the output is unmuted or releasing drives `mute_oe`=1, `mute_out`=MUTE_LVL and `fade_start`=0 at the next clock edge.
- R8: While `mute_req` is 1, no release happens, however many ticks arrive. After a re-mute, the settle count restarts from zero once `mute_req` drops.
- R9: The unmute level is driven only while `dac_pwrdn`=0 and `dac_drv_en`=1.
- R10: `fade_done` has no effect outside a fade release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | One-cycle pulse from the prescaled settle timebase |
| mute_req | input | 1 | Request to mute the output at once |
| fade_mode | input | 1 | 1 selects fade release, 0 selects a hard step |
| fade_done | input | 1 | Fade driver reports that the ramp has finished |
| dac_pwrdn | output | 1 | DAC powerdown, 1 = powered down |
| dac_drv_en | output | 1 | DAC analog driver enable |
| mute_oe | output | 1 | Output enable of the mute pin |
| mute_out | output | 1 | Data level of the mute pin |
| fade_start | output | 1 | Asks the fade driver to ramp the line out of mute |

## Verification
The assertions check on every cycle the ordering invariants: drivers never on while the DAC is powered down, power-up only while mute is driven, unmute only with the DAC running, the one-edge mute on a request, fade start only after the settle count, and the timer bound. Only the scenarios can show the exact edge of each start-up step, that early ticks and stray `fade_done` pulses are ignored, and that a request restarts the settle wait. They also show the full step and fade release sequences, and a fade aborted part way through.

// File: rtl/mute_seq_pkg.sv
package mute_seq_pkg;

  typedef enum logic [2:0] {
    ST_RESET_HIZ  = 3'd0,
    ST_DRIVE_MUTE = 3'd1,
    ST_DAC_ENABLE = 3'd2,
    ST_SETTLE     = 3'd3,
    ST_RELEASE    = 3'd4,
    ST_RUN        = 3'd5,
    ST_REMUTE     = 3'd6
  } mseq_state_e;

  typedef struct packed {
    logic pin_oe;
    logic pin_muted;
    logic dac_pwrdn;
    logic drv_en;
    logic fade_go;
  } mseq_ctl_t;

endpackage

// File: rtl/mute_seq_timer.sv
module mute_seq_timer #(
  parameter int unsigned LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic done
);
  localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run) begin
      cnt_q <= '0;
    end else if (tick && (cnt_q != LIM)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done = (cnt_q == LIM);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM); // R5
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0)); // R8

endmodule

// File: rtl/mute_seq_fsm.sv
module mute_seq_fsm
  import mute_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mute_req,
  input  logic        fade_mode,
  input  logic        fade_done,
  input  logic        settle_done,
  output mseq_state_e state_q,
  output mseq_state_e state_d,
  output logic        fade_sel_d
);
  logic fade_sel_q;

  always_comb begin
    state_d    = state_q;
    fade_sel_d = fade_sel_q;
    unique case (state_q)
      ST_RESET_HIZ:  state_d = ST_DRIVE_MUTE;
      ST_DRIVE_MUTE: state_d = ST_DAC_ENABLE;
      ST_DAC_ENABLE: state_d = ST_SETTLE;
      ST_SETTLE: begin
        if (settle_done && !mute_req) begin
          state_d    = ST_RELEASE;
          fade_sel_d = fade_mode;
        end
      end
      ST_RELEASE: begin
        if (mute_req)                      state_d = ST_REMUTE;
        else if (!fade_sel_q || fade_done) state_d = ST_RUN;
      end
      ST_RUN: begin
        if (mute_req) state_d = ST_REMUTE;
      end
      ST_REMUTE: begin
        if (!mute_req) state_d = ST_SETTLE;
      end
      default: state_d = ST_RESET_HIZ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_RESET_HIZ;
      fade_sel_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      fade_sel_q <= fade_sel_d;
    end
  end

  AST_SETTLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SETTLE && (!settle_done || mute_req)) |=> (state_q == ST_SETTLE)); // R8
  AST_REMUTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_REMUTE && mute_req) |=> (state_q == ST_REMUTE)); // R8

endmodule

// File: rtl/mute_seq_pin.sv
module mute_seq_pin
  import mute_seq_pkg::*;
#(
  parameter logic MUTE_LVL = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  mseq_state_e state_d,
  input  logic        fade_sel_d,
  output mseq_ctl_t   ctl_q
);
  localparam mseq_ctl_t CTL_RST = '{pin_oe: 1'b0, pin_muted: 1'b1,
                                    dac_pwrdn: 1'b1, drv_en: 1'b0, fade_go: 1'b0};

  mseq_ctl_t ctl_d;

  always_comb begin
    ctl_d = CTL_RST;
    unique case (state_d)
      ST_RESET_HIZ:  ctl_d = CTL_RST;
      ST_DRIVE_MUTE: ctl_d.pin_oe = 1'b1;
      ST_DAC_ENABLE: begin
        ctl_d.pin_oe    = 1'b1;
        ctl_d.dac_pwrdn = 1'b0;
      end
      ST_SETTLE, ST_REMUTE: begin
        ctl_d.pin_oe    = 1'b1;
        ctl_d.dac_pwrdn = 1'b0;
        ctl_d.drv_en    = 1'b1;
      end
      ST_RELEASE: begin
        ctl_d.dac_pwrdn = 1'b0;
        ctl_d.drv_en    = 1'b1;
        ctl_d.pin_oe    = !fade_sel_d;
        ctl_d.pin_muted = fade_sel_d;
        ctl_d.fade_go   = fade_sel_d;
      end
      ST_RUN: begin
        ctl_d.pin_oe    = 1'b1;
        ctl_d.pin_muted = 1'b0;
        ctl_d.dac_pwrdn = 1'b0;
        ctl_d.drv_en    = 1'b1;
      end
      default: ctl_d = CTL_RST;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= CTL_RST;
    else        ctl_q <= ctl_d;
  end

  AST_HANDOFF_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q.fade_go |-> ctl_q.pin_muted); // R6

endmodule

// File: rtl/mute_seq_ctrl.sv
module mute_seq_ctrl
  import mute_seq_pkg::*;
#(
  parameter int unsigned SETTLE_TICKS = 1000,
  parameter logic        MUTE_LVL     = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic mute_req,
  input  logic fade_mode,
  input  logic fade_done,
  output logic dac_pwrdn,
  output logic dac_drv_en,
  output logic mute_oe,
  output logic mute_out,
  output logic fade_start
);
  mseq_state_e st_q, st_d;
  logic        fade_sel_d;
  logic        tmr_done;
  mseq_ctl_t   ctl;

  mute_seq_timer #(.LIMIT(SETTLE_TICKS)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (st_q == ST_SETTLE),
    .tick  (tick_en),
    .done  (tmr_done)
  );

  mute_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .mute_req    (mute_req),
    .fade_mode   (fade_mode),
    .fade_done   (fade_done),
    .settle_done (tmr_done),
    .state_q     (st_q),
    .state_d     (st_d),
    .fade_sel_d  (fade_sel_d)
  );

  mute_seq_pin #(.MUTE_LVL(MUTE_LVL)) u_pin (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_d    (st_d),
    .fade_sel_d (fade_sel_d),
    .ctl_q      (ctl)
  );

  assign mute_oe    = ctl.pin_oe;
  assign mute_out   = ctl.pin_muted ? MUTE_LVL : !MUTE_LVL;
  assign dac_pwrdn  = ctl.dac_pwrdn;
  assign dac_drv_en = ctl.drv_en;
  assign fade_start = ctl.fade_go;

  AST_DRV_NEEDS_PWR: assert property (@(posedge clk) disable iff (!rst_n)
    dac_drv_en |-> !dac_pwrdn); // R4
  AST_PWRUP_MUTED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dac_pwrdn) |-> (mute_oe && mute_out == MUTE_LVL)); // R3
  AST_UNMUTE_DAC_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_oe && mute_out != MUTE_LVL) |-> (!dac_pwrdn && dac_drv_en)); // R9
  AST_FADE_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fade_start) |-> $past(tmr_done)); // R6
  AST_INSTANT_REMUTE: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_RUN || st_q == ST_RELEASE) && mute_req)
      |=> (mute_oe && mute_out == MUTE_LVL && !fade_start)); // R7

endmodule

// File: tb/mute_seq_ctrl_tb.sv
module mute_seq_ctrl_tb;
  localparam int unsigned NTICK = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0, mute_req = 1'b0, fade_mode = 1'b0, fade_done = 1'b0;
  logic dac_pwrdn, dac_drv_en, mute_oe, mute_out, fade_start;
  int   n_run = 0, n_fail = 0;
  bit   finished = 1'b0;

  // Vector order {oe, out, pwrdn, drv, fade}, mute level is 1.
  localparam logic [4:0] V_RST   = 5'b01100;
  localparam logic [4:0] V_DRIVE = 5'b11100;
  localparam logic [4:0] V_DACON = 5'b11000;
  localparam logic [4:0] V_MUTED = 5'b11010;
  localparam logic [4:0] V_OPEN  = 5'b10010;
  localparam logic [4:0] V_FADE  = 5'b01011;

  always #4 clk = ~clk;

  mute_seq_ctrl #(.SETTLE_TICKS(NTICK), .MUTE_LVL(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .mute_req(mute_req),
    .fade_mode(fade_mode), .fade_done(fade_done), .dac_pwrdn(dac_pwrdn),
    .dac_drv_en(dac_drv_en), .mute_oe(mute_oe), .mute_out(mute_out),
    .fade_start(fade_start)
  );

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(string req, logic [4:0] exp);
    logic [4:0] act;
    act = {mute_oe, mute_out, dac_pwrdn, dac_drv_en, fade_start};
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic give_tick();
    tick_en = 1'b1; cyc(); tick_en = 1'b0; cyc();
  endtask

  // Reset and the three start-up edges; tick_en held high to show early ticks are ignored.
  task automatic t_reset_startup(logic fmode);
    fade_mode = fmode;
    rst_n = 1'b0; tick_en = 1'b1;
    cyc(); cyc();
    chk("R1 reset state", V_RST);
    rst_n = 1'b1;
    cyc(); chk("R2 mute driven", V_DRIVE);
    cyc(); chk("R3 dac powered", V_DACON);
    cyc(); chk("R3 drivers on", V_MUTED);
    tick_en = 1'b0;
  endtask

  // NTICK-1 ticks then the last one; returns one edge after the last counted tick.
  task automatic settle_to_release(string req);
    for (int i = 0; i < NTICK - 1; i++) give_tick();
    chk({req, " muted before last tick"}, V_MUTED);
    tick_en = 1'b1; cyc(); tick_en = 1'b0;
    chk({req, " muted on last tick edge"}, V_MUTED);
    cyc();
  endtask

  task automatic t_step_release();
    settle_to_release("R5");
    chk("R5 step unmute", V_OPEN);
    cyc(); chk("R5 running", V_OPEN);
  endtask

  task automatic t_remute();
    mute_req = 1'b1; cyc();
    chk("R7 instant remute", V_MUTED);
    for (int i = 0; i < NTICK + 2; i++) give_tick();
    chk("R8 held while requested", V_MUTED);
    mute_req = 1'b0; cyc();
    chk("R8 back to settle", V_MUTED);
    settle_to_release("R8");
    chk("R8 release after restart", V_OPEN);
  endtask

  task automatic t_hold_in_settle();
    mute_req = 1'b1; cyc();
    mute_req = 1'b0; cyc();
    mute_req = 1'b1;
    for (int i = 0; i < NTICK + 1; i++) give_tick();
    chk("R8 request blocks release", V_MUTED);
    mute_req = 1'b0; cyc();
    chk("R8 release on request drop", V_OPEN);
  endtask

  task automatic t_fade();
    fade_done = 1'b1; cyc(); fade_done = 1'b0;
    chk("R10 stray fade_done", V_MUTED);
    settle_to_release("R5 fade");
    chk("R6 fade handoff", V_FADE);
    cyc(); cyc(); cyc();
    chk("R6 fade held", V_FADE);
    fade_done = 1'b1; cyc(); fade_done = 1'b0;
    chk("R6 fade finished", V_OPEN);
    fade_done = 1'b1; cyc(); fade_done = 1'b0;
    chk("R10 fade_done in run", V_OPEN);
  endtask

  task automatic t_fade_abort();
    mute_req = 1'b1; cyc();
    chk("R7 remute from run", V_MUTED);
    mute_req = 1'b0; cyc();
    settle_to_release("R6 abort");
    chk("R6 second fade", V_FADE);
    mute_req = 1'b1; cyc();
    chk("R7 fade aborted", V_MUTED);
    mute_req = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    #1;
    t_reset_startup(1'b0);
    t_step_release();
    t_remute();
    t_hold_in_settle();
    t_reset_startup(1'b1);
    t_fade();
    t_fade_abort();
    summary();
  end

endmodule